// File: doc/BRIEF.md
# Memory-Indirect Jump-and-Link Microsequencer

This block is the microcoded control unit and bus-based datapath that carries out a memory-indirect jump-and-link instruction of the form `JALM offset(rs)`. The instruction fetch has already happened when it begins. The fetch stage hands over three things: the instruction fields, the program counter as it was before the fetch, and a start strobe. From there the unit computes a target location, saves the return address in the link register (register 31), and reads the new program counter from memory.

The datapath has operand latches A and B, a memory address latch, an instruction field latch, the program counter, a 32-entry register file and a small adder. All of them talk over one shared bus. Each micro-instruction names exactly one bus source plus any set of load enables.

The sequence takes five micro-steps:

1. The base register goes to B.
2. A+4 goes to the link register. A still holds the pre-fetch PC.
3. The sign-extended offset goes to A.
4. A+B goes to the address latch.
5. Memory is read into the PC.

The last step holds until memory signals ready. Afterwards the unit returns to its fetch state.

Top module: `jalm_useq`

## Requirements
- R1: After reset the unit is idle: `busy`=0, `mem_req`=0, `done`=0 and `pc`=0.
- R2: A `start` sampled while idle sets `pc` to `fetch_pc`+4 on that clock edge. This models the increment done during fetch.
- R3: On completion, register 31 holds `fetch_pc`+4, with the sum taken modulo 2^32. It does not hold `fetch_pc`+8.
- R4: While `mem_req` is high, `mem_addr` equals R[`fetch_rs`] + sign-extended `fetch_imm`. Bit 15 of the immediate is its sign. Register 0 reads as 0.
- R5: On the edge where `mem_req` and `mem_ready` are both high, `pc` loads `mem_rdata`.
- R6: With `mem_ready` high from the first request cycle, `busy` stays high for exactly five cycles. `done` pulses in the fifth cycle, and the unit is idle on the next cycle.
- R7: While `mem_req` is high and `mem_ready` is low, `mem_req` stays high and `mem_addr` and `pc` hold. Each wait cycle adds one cycle to `busy`.
- R8: A register-file write to index 0 is discarded, so index 0 reads 0 afterwards. A write to index 31 is kept.
- R9: When `fetch_rs`=31, the base register is read before the link write. The address therefore uses the old R[31].
- R10: An external register write is honoured only while idle. One issued in the same cycle as `start` is seen by the base-register read. One issued while busy has no effect.
- R11: `start` while busy is ignored. The running sequence's `pc` and link value are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Fetch complete, begin the sequence |
| fetch_rs | input | 5 | Base register index from the fetched instruction |
| fetch_imm | input | 16 | Offset field from the fetched instruction |
| fetch_pc | input | 32 | PC value before the fetch increment |
| ext_we | input | 1 | External register-file write enable (honoured when idle) |
| ext_idx | input | 5 | External write index |
| ext_wdata | input | 32 | External write data |
| rd_idx | input | 5 | Register-file observation read index |
| rd_data | output | 32 | Register-file observation read data |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read address |
| mem_rdata | input | 32 | Memory read data |
| mem_ready | input | 1 | Memory read data valid |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Final step completes this cycle |
| pc | output | 32 | Program counter |

## Verification
An external register write and `start` can fall in the same clock cycle. The write updates the register file on the same edge that launches the sequence. The bench provokes this in every table vector by presenting the base value on the external write port alongside `start`. It judges the outcome by the memory address seen during the request: that address must be built from the freshly written value. The rs=31 vector adds a second overlap, where the register written alongside `start` is also the link target. There the bench checks that the address uses the written value and that register 31 ends holding the return address.

// File: rtl/jalm_pkg.sv
package jalm_pkg;

  typedef enum logic [2:0] {
    ST_FETCH  = 3'd0,
    ST_RDBASE = 3'd1,
    ST_LINK   = 3'd2,
    ST_IMM    = 3'd3,
    ST_EADDR  = 3'd4,
    ST_LOAD   = 3'd5
  } ustate_t;

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_RF   = 3'd1,
    SRC_ALU  = 3'd2,
    SRC_IMM  = 3'd3,
    SRC_MEM  = 3'd4
  } bus_src_t;

  typedef enum logic {
    OP_INC4 = 1'b0,
    OP_ADD  = 1'b1
  } alu_op_t;

  typedef struct packed {
    bus_src_t src;
    alu_op_t  op;
    logic     ld_a;
    logic     ld_b;
    logic     ld_ma;
    logic     ld_pc;
    logic     link_we;
    logic     mem_req;
  } uop_t;

endpackage

// File: rtl/jalm_urom.sv
module jalm_urom
  import jalm_pkg::*;
(
  input  ustate_t st,
  output uop_t    uop
);
  always_comb begin
    uop = '{src: SRC_NONE, op: OP_INC4, ld_a: 1'b0, ld_b: 1'b0, ld_ma: 1'b0,
            ld_pc: 1'b0, link_we: 1'b0, mem_req: 1'b0};
    unique case (st)
      ST_RDBASE: begin uop.src = SRC_RF;  uop.ld_b = 1'b1; end
      ST_LINK:   begin uop.src = SRC_ALU; uop.op = OP_INC4; uop.link_we = 1'b1; end
      ST_IMM:    begin uop.src = SRC_IMM; uop.ld_a = 1'b1; end
      ST_EADDR:  begin uop.src = SRC_ALU; uop.op = OP_ADD; uop.ld_ma = 1'b1; end
      ST_LOAD:   begin uop.src = SRC_MEM; uop.ld_pc = 1'b1; uop.mem_req = 1'b1; end
      default:   ;
    endcase
  end
endmodule

// File: rtl/jalm_fsm.sv
module jalm_fsm
  import jalm_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  logic    mem_ready,
  output ustate_t st
);
  ustate_t st_nxt;

  always_comb begin
    st_nxt = st;
    unique case (st)
      ST_FETCH:  if (start) st_nxt = ST_RDBASE;
      ST_RDBASE: st_nxt = ST_LINK;
      ST_LINK:   st_nxt = ST_IMM;
      ST_IMM:    st_nxt = ST_EADDR;
      ST_EADDR:  st_nxt = ST_LOAD;
      ST_LOAD:   if (mem_ready) st_nxt = ST_FETCH;
      default:   st_nxt = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_FETCH;
    else        st <= st_nxt;
  end
endmodule

// File: rtl/jalm_regfile.sv
module jalm_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            we,
  input  logic [AW-1:0]   widx,
  input  logic [XLEN-1:0] wdata,
  input  logic [AW-1:0]   ridx_a,
  output logic [XLEN-1:0] rdata_a,
  input  logic [AW-1:0]   ridx_b,
  output logic [XLEN-1:0] rdata_b
);
  logic [XLEN-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (we && (widx != '0)) regs[widx] <= wdata;
  end

  assign rdata_a = (ridx_a == '0) ? '0 : regs[ridx_a];
  assign rdata_b = (ridx_b == '0) ? '0 : regs[ridx_b];
endmodule

// File: rtl/jalm_dp.sv
module jalm_dp
  import jalm_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int AW    = 5,
  parameter int IMM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  uop_t             uop,
  input  logic             fetch_go,
  input  logic [AW-1:0]    fetch_rs,
  input  logic [IMM_W-1:0] fetch_imm,
  input  logic [XLEN-1:0]  fetch_pc,
  input  logic [XLEN-1:0]  rf_rdata,
  input  logic [XLEN-1:0]  mem_rdata,
  input  logic             mem_ready,
  output logic [AW-1:0]    ir_rs,
  output logic [XLEN-1:0]  bus,
  output logic [XLEN-1:0]  ma,
  output logic [XLEN-1:0]  pc
);
  localparam logic [XLEN-1:0] FOUR = XLEN'(4);

  logic [IMM_W-1:0] ir_imm;
  logic [XLEN-1:0]  lat_a, lat_b, alu_y, imm_x;
  logic             pc_en;

  assign imm_x = {{(XLEN-IMM_W){ir_imm[IMM_W-1]}}, ir_imm};
  assign alu_y = (uop.op == OP_ADD) ? (lat_a + lat_b) : (lat_a + FOUR);

  always_comb begin
    unique case (uop.src)
      SRC_RF:  bus = rf_rdata;
      SRC_ALU: bus = alu_y;
      SRC_IMM: bus = imm_x;
      SRC_MEM: bus = mem_rdata;
      default: bus = '0;
    endcase
  end

  assign pc_en = uop.ld_pc & mem_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir_rs  <= '0;
      ir_imm <= '0;
    end else if (fetch_go) begin
      ir_rs  <= fetch_rs;
      ir_imm <= fetch_imm;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          lat_a <= '0;
    else if (fetch_go)   lat_a <= fetch_pc;
    else if (uop.ld_a)   lat_a <= bus;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          lat_b <= '0;
    else if (uop.ld_b)   lat_b <= bus;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ma <= '0;
    else if (uop.ld_ma)  ma <= bus;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pc <= '0;
    else if (fetch_go)   pc <= fetch_pc + FOUR;
    else if (pc_en)      pc <= bus;
  end
endmodule

// File: rtl/jalm_useq.sv
module jalm_useq
  import jalm_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int NREG     = 32,
  parameter int IMM_W    = 16,
  localparam int AW      = $clog2(NREG),
  localparam int LINK_IX = NREG - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [AW-1:0]    fetch_rs,
  input  logic [IMM_W-1:0] fetch_imm,
  input  logic [XLEN-1:0]  fetch_pc,
  input  logic             ext_we,
  input  logic [AW-1:0]    ext_idx,
  input  logic [XLEN-1:0]  ext_wdata,
  input  logic [AW-1:0]    rd_idx,
  output logic [XLEN-1:0]  rd_data,
  output logic             mem_req,
  output logic [XLEN-1:0]  mem_addr,
  input  logic [XLEN-1:0]  mem_rdata,
  input  logic             mem_ready,
  output logic             busy,
  output logic             done,
  output logic [XLEN-1:0]  pc
);
  ustate_t         st;
  uop_t            uop;
  logic            idle, fetch_go, rf_we;
  logic [AW-1:0]   ir_rs, rf_widx;
  logic [XLEN-1:0] bus, rf_wdata, rf_rdata;

  assign idle     = (st == ST_FETCH);
  assign fetch_go = idle & start;
  assign busy     = ~idle;
  assign mem_req  = uop.mem_req;
  assign done     = uop.mem_req & mem_ready;

  assign rf_we    = uop.link_we | (ext_we & idle);
  assign rf_widx  = uop.link_we ? AW'(LINK_IX) : ext_idx;
  assign rf_wdata = uop.link_we ? bus : ext_wdata;

  jalm_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .mem_ready(mem_ready), .st(st)
  );

  jalm_urom u_urom (.st(st), .uop(uop));

  jalm_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk(clk), .we(rf_we), .widx(rf_widx), .wdata(rf_wdata),
    .ridx_a(ir_rs), .rdata_a(rf_rdata), .ridx_b(rd_idx), .rdata_b(rd_data)
  );

  jalm_dp #(.XLEN(XLEN), .AW(AW), .IMM_W(IMM_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .uop(uop), .fetch_go(fetch_go),
    .fetch_rs(fetch_rs), .fetch_imm(fetch_imm), .fetch_pc(fetch_pc),
    .rf_rdata(rf_rdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .ir_rs(ir_rs), .bus(bus), .ma(mem_addr), .pc(pc)
  );
endmodule

// File: rtl/jalm_useq_chk.sv
module jalm_useq_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic            mem_req,
  input logic            mem_ready,
  input logic [XLEN-1:0] mem_addr,
  input logic [XLEN-1:0] mem_rdata,
  input logic [XLEN-1:0] fetch_pc,
  input logic [XLEN-1:0] pc
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req); // R1

  AST_START_PC: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (pc == $past(fetch_pc) + XLEN'(4))); // R2

  AST_DONE_PC: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (pc == $past(mem_rdata))); // R5

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R6

  AST_STALL_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr))); // R7

  AST_STALL_PC: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> $stable(pc)); // R7

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy); // R11
endmodule

bind jalm_useq jalm_useq_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .mem_req(mem_req), .mem_ready(mem_ready), .mem_addr(mem_addr),
  .mem_rdata(mem_rdata), .fetch_pc(fetch_pc), .pc(pc)
);

// File: tb/tb_jalm_useq.sv
module tb_jalm_useq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [4:0]  fetch_rs;
  logic [15:0] fetch_imm;
  logic [31:0] fetch_pc;
  logic        ext_we;
  logic [4:0]  ext_idx;
  logic [31:0] ext_wdata;
  logic [4:0]  rd_idx;
  logic [31:0] rd_data;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic [31:0] mem_rdata;
  logic        mem_ready;
  logic        busy, done;
  logic [31:0] pc;

  int total = 0;
  int bad   = 0;
  int lat_cfg = 0;
  int wcnt;

  always #5 clk = ~clk;

  jalm_useq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .fetch_rs(fetch_rs),
    .fetch_imm(fetch_imm), .fetch_pc(fetch_pc), .ext_we(ext_we),
    .ext_idx(ext_idx), .ext_wdata(ext_wdata), .rd_idx(rd_idx),
    .rd_data(rd_data), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready), .busy(busy),
    .done(done), .pc(pc)
  );

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {a[15:0], ~a[31:16]} ^ 32'h1357_9BDF;
  endfunction

  // synchronous memory model: ready after lat_cfg wait cycles
  always_ff @(posedge clk) begin
    if (!mem_req) wcnt <= 0;
    else          wcnt <= wcnt + 1;
  end
  assign mem_ready = mem_req && (wcnt >= lat_cfg);
  assign mem_rdata = mem_req ? mem_word(mem_addr) : 32'hDEAD_BEEF;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // fields: rs(5) imm(16) base(32) fetch_pc(32) latency(4)
  localparam int NV = 6;
  localparam logic [88:0] VEC [NV] = '{
    {5'd5,  16'h0010, 32'h0000_1000, 32'h0000_0400, 4'd0},
    {5'd7,  16'hFFF0, 32'h0000_2000, 32'h0000_0800, 4'd2},
    {5'd0,  16'h7FFC, 32'h0000_0000, 32'h0000_0100, 4'd1},
    {5'd31, 16'h0008, 32'h0000_3000, 32'h0000_0C00, 4'd0},
    {5'd12, 16'h8000, 32'h0001_0000, 32'hFFFF_FFFC, 4'd3},
    {5'd1,  16'h0000, 32'hABCD_0000, 32'h0000_0010, 4'd0}
  };

  // Launch at a negedge; ext write of base lands with start (R10).
  task automatic run_jalm(input logic [4:0] rs, input logic [15:0] imm,
                          input logic [31:0] base, input logic [31:0] fpc,
                          input int lat, input bit poke_busy, output int cycles,
                          output logic [31:0] cap_addr);
    lat_cfg   = lat;
    fetch_rs  = rs;
    fetch_imm = imm;
    fetch_pc  = fpc;
    ext_we    = (rs != 5'd0);
    ext_idx   = rs;
    ext_wdata = base;
    start     = 1'b1;
    @(negedge clk);
    start  = 1'b0;
    ext_we = 1'b0;
    chk("R2 pc after start", pc, fpc + 32'd4);
    cycles   = 0;
    cap_addr = 'x;
    while (busy) begin
      if (mem_req) cap_addr = mem_addr;
      if (poke_busy && cycles == 1) begin
        start = 1'b1; fetch_pc = 32'h7777_0000;
        ext_we = 1'b1; ext_idx = 5'd31; ext_wdata = 32'h5555_5555;
      end
      cycles++;
      @(negedge clk);
      start = 1'b0; ext_we = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R6 watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cyc;
    logic [31:0] ea, cap, expected_base;
    rst_n = 1'b0; start = 1'b0; fetch_rs = '0; fetch_imm = '0; fetch_pc = '0;
    ext_we = 1'b0; ext_idx = '0; ext_wdata = '0; rd_idx = '0;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", {31'd0, busy}, 32'd0);
    chk("R1 pc in reset", pc, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after reset", {31'd0, busy}, 32'd0);
    chk("R1 mem_req after reset", {31'd0, mem_req}, 32'd0);
    chk("R1 done after reset", {31'd0, done}, 32'd0);

    // table walk: R3 R4 R5 R6 R7 R9 R10
    for (int i = 0; i < NV; i++) begin
      logic [4:0]  v_rs   = VEC[i][88:84];
      logic [15:0] v_imm  = VEC[i][83:68];
      logic [31:0] v_base = VEC[i][67:36];
      logic [31:0] v_pc   = VEC[i][35:4];
      int          v_lat  = int'(VEC[i][3:0]);
      run_jalm(v_rs, v_imm, v_base, v_pc, v_lat, 1'b0, cyc, cap);
      expected_base = (v_rs == 5'd0) ? 32'd0 : v_base;
      ea = expected_base + {{16{v_imm[15]}}, v_imm};
      chk((v_rs == 5'd31) ? "R9 addr uses old link reg" : "R4 R10 effective address", cap, ea);
      chk((v_lat == 0) ? "R6 five micro-steps" : "R7 stall cycles", cyc, 32'(5 + v_lat));
      chk("R5 pc from memory", pc, mem_word(ea));
      rd_idx = 5'd31;
      #1;
      chk("R3 link value", rd_data, v_pc + 32'd4);
    end

    // R8: write to register 0 discarded, 31 kept
    ext_we = 1'b1; ext_idx = 5'd0; ext_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    ext_idx = 5'd31; ext_wdata = 32'h1234_5678;
    @(negedge clk);
    ext_we = 1'b0;
    rd_idx = 5'd0; #1;
    chk("R8 reg0 stays zero", rd_data, 32'd0);
    rd_idx = 5'd31; #1;
    chk("R8 reg31 writable", rd_data, 32'h1234_5678);

    // R11 + R10: start and ext write to r31 while busy both ignored
    run_jalm(5'd3, 16'h0020, 32'h0000_4000, 32'h0000_0200, 1, 1'b1, cyc, cap);
    chk("R11 addr unaffected by start while busy", cap, 32'h0000_4020);
    chk("R11 pc unaffected by start while busy", pc, mem_word(32'h0000_4020));
    rd_idx = 5'd31; #1;
    chk("R10 busy write ignored, link kept", rd_data, 32'h0000_0204);
    chk("R11 idle after run", {31'd0, busy}, 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule